// File: doc/BRIEF.md
# SIMD Lane-Wise Compare Unit

This block compares two packed vectors lane by lane and returns a lane mask. Each lane of the result is filled with ones when the selected condition holds for that lane and with zeros when it fails. A single datapath serves 8, 16 and 32-bit integer lanes, signed or unsigned, and 32-bit single-precision float lanes. A compare-with-zero mode replaces the second operand with the constant zero and opens two extra conditions, less-or-equal and less-than.

The operand size is either 64 or 128 bits. In 64-bit mode only the low half is compared and the upper half of the mask is zero. Combinations of condition, lane type and mode that are not allowed are not executed. They raise an error output and return an all-zero mask. The result is registered once, so each request produces its mask exactly one clock after it is presented.

Top module: `simd_cmp_unit`

## Requirements
- R1: Every result lane is either all ones (condition true) or all zeros (condition false); the result lane width equals the operand lane width.
- R2: `elemType` encodes the lane type: 0 signed 8-bit, 1 signed 16-bit, 2 signed 32-bit, 3 unsigned 8-bit, 4 unsigned 16-bit, 5 unsigned 32-bit, 6 single-precision float, 7 reserved and illegal.
- R3: `cmpOp` encodes the condition, evaluated as A relation B per lane: 0 equal, 1 greater-or-equal, 2 greater-than, 3 less-or-equal, 4 less-than; codes 5 to 7 are illegal.
- R4: Ordered integer compares use two's-complement order for signed types and plain binary order for unsigned types.
- R5: Equality on integer lanes gives the same mask for the signed and unsigned type of the same width.
- R6: With `zeroMode` high, every B lane is taken as zero and `opB` has no effect; codes 3 and 4 are legal only with `zeroMode` high.
- R7: With `zeroMode` high, ordered conditions (codes 1 to 4) on unsigned types are illegal; equality on unsigned types stays legal.
- R8: On float lanes, a lane where either operand is a NaN (exponent all ones, fraction non-zero) yields zeros for every condition, equality included.
- R9: On float lanes, positive and negative zero compare as equal and neither is less than the other.
- R10: With `fullWidth` low, only the low 64 bits are compared and result bits 127:64 are zero.
- R11: An illegal combination drives `outErr` high with the request and forces the whole mask to zero.
- R12: `outValid` follows `inValid` by exactly one clock; a synchronous reset clears `outValid`, `outErr` and `outMask`, and cycles without a request leave the mask zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe |
| opA | input | 128 | First operand vector |
| opB | input | 128 | Second operand vector, ignored in zero mode |
| fullWidth | input | 1 | 1: 128-bit operation, 0: 64-bit operation |
| elemType | input | 3 | Lane type code (see R2) |
| cmpOp | input | 3 | Condition code (see R3) |
| zeroMode | input | 1 | Compare opA against zero |
| outValid | output | 1 | Result strobe, one clock after inValid |
| outMask | output | 128 | Lane mask result |
| outErr | output | 1 | Illegal combination flag for this result |

## Verification
Two zeroing paths can coincide: the illegal-combination override and the 64-bit upper-half clearing. The bench provokes both at once with an unsigned ordered compare in zero mode at 64 bits, on operands whose low lanes would otherwise all match, and expects the error flag together with an all-zero mask rather than a half-filled one. A second overlap, NaN lanes and signed-zero lanes in the same float vector, is judged lane by lane against hand-derived masks.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

  typedef enum logic [2:0] {
    ET_S8  = 3'd0,
    ET_S16 = 3'd1,
    ET_S32 = 3'd2,
    ET_U8  = 3'd3,
    ET_U16 = 3'd4,
    ET_U32 = 3'd5,
    ET_F32 = 3'd6,
    ET_BAD = 3'd7
  } elemKind_e;

  typedef enum logic [2:0] {
    OP_EQ = 3'd0,
    OP_GE = 3'd1,
    OP_GT = 3'd2,
    OP_LE = 3'd3,
    OP_LT = 3'd4
  } cmpCode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic w8;
    logic w16;
    logic w32;
    logic sgn;
    logic flt;
    logic useEq;
    logic useGe;
    logic useGt;
    logic useLe;
    logic useLt;
    logic zeroB;
    logic full;
    logic err;
  } cmpStrobes_t;

  function automatic logic pickHit(cmpStrobes_t s, logic eq, logic lt, logic gt);
    return (s.useEq & eq) | (s.useGe & (eq | gt)) | (s.useGt & gt) |
           (s.useLe & (eq | lt)) | (s.useLt & lt);
  endfunction

endpackage

// File: rtl/simd_cmp_ctrl.sv
module simd_cmp_ctrl
  import simd_cmp_pkg::*;
(
  input  logic [2:0]  elemType,
  input  logic [2:0]  cmpOp,
  input  logic        zeroMode,
  input  logic        fullWidth,
  output cmpStrobes_t st
);

  logic isUns;
  logic needZero;
  logic badType;
  logic badOp;

  always_comb begin
    st       = '0;
    isUns    = 1'b0;
    badType  = 1'b0;
    case (elemKind_e'(elemType))
      ET_S8:  begin st.w8  = 1'b1; st.sgn = 1'b1; end
      ET_S16: begin st.w16 = 1'b1; st.sgn = 1'b1; end
      ET_S32: begin st.w32 = 1'b1; st.sgn = 1'b1; end
      ET_U8:  begin st.w8  = 1'b1; isUns = 1'b1; end
      ET_U16: begin st.w16 = 1'b1; isUns = 1'b1; end
      ET_U32: begin st.w32 = 1'b1; isUns = 1'b1; end
      ET_F32: begin st.w32 = 1'b1; st.flt = 1'b1; end
      default: badType = 1'b1;
    endcase

    st.useEq = (cmpOp == OP_EQ);
    st.useGe = (cmpOp == OP_GE);
    st.useGt = (cmpOp == OP_GT);
    st.useLe = (cmpOp == OP_LE);
    st.useLt = (cmpOp == OP_LT);
    badOp    = (cmpOp > OP_LT);
    needZero = st.useLe | st.useLt;

    st.zeroB = zeroMode;
    st.full  = fullWidth;
    st.err   = badType | badOp | (needZero & ~zeroMode) |
               (zeroMode & isUns & ~st.useEq);
  end

endmodule

// File: rtl/simd_cmp_datapath.sv
module simd_cmp_datapath
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  cmpStrobes_t       st,
  output logic [DATA_W-1:0] mask
);

  localparam int N8   = DATA_W / 8;
  localparam int N16  = DATA_W / 16;
  localparam int N32  = DATA_W / 32;
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] bEff;
  logic [DATA_W-1:0] m8, m16, m32i, m32f, raw;

  assign bEff = st.zeroB ? '0 : b;

  for (genvar g = 0; g < N8; g++) begin : g_byte
    logic [7:0] x, y;
    logic eq, lt;
    assign x  = a[8*g +: 8];
    assign y  = bEff[8*g +: 8];
    assign eq = (x == y);
    assign lt = st.sgn ? ($signed(x) < $signed(y)) : (x < y);
    assign m8[8*g +: 8] = {8{pickHit(st, eq, lt, ~eq & ~lt)}};
  end

  for (genvar g = 0; g < N16; g++) begin : g_half
    logic [15:0] x, y;
    logic eq, lt;
    assign x  = a[16*g +: 16];
    assign y  = bEff[16*g +: 16];
    assign eq = (x == y);
    assign lt = st.sgn ? ($signed(x) < $signed(y)) : (x < y);
    assign m16[16*g +: 16] = {16{pickHit(st, eq, lt, ~eq & ~lt)}};
  end

  for (genvar g = 0; g < N32; g++) begin : g_word
    logic [31:0] x, y;
    logic eq, lt;
    logic fNan, fZero, fEq, fLt;
    assign x  = a[32*g +: 32];
    assign y  = bEff[32*g +: 32];
    assign eq = (x == y);
    assign lt = st.sgn ? ($signed(x) < $signed(y)) : (x < y);
    assign m32i[32*g +: 32] = {32{pickHit(st, eq, lt, ~eq & ~lt)}};

    // float path: sign-magnitude order, signed zeros merged, NaN unordered
    assign fNan  = (&x[30:23] & |x[22:0]) | (&y[30:23] & |y[22:0]);
    assign fZero = ~|x[30:0] & ~|y[30:0];
    always_comb begin
      if (fZero) begin
        fEq = 1'b1;
        fLt = 1'b0;
      end else begin
        fEq = (x == y);
        if (x[31] != y[31])  fLt = x[31];
        else if (x[31])      fLt = (x[30:0] > y[30:0]);
        else                 fLt = (x[30:0] < y[30:0]);
      end
    end
    assign m32f[32*g +: 32] = {32{~fNan & pickHit(st, fEq, fLt, ~fEq & ~fLt)}};
  end

  always_comb begin
    if (st.w8)       raw = m8;
    else if (st.w16) raw = m16;
    else if (st.w32) raw = st.flt ? m32f : m32i;
    else             raw = '0;
  end

  assign mask = st.err  ? '0 :
                st.full ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};

endmodule

// File: rtl/simd_cmp_unit.sv
module simd_cmp_unit
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              fullWidth,
  input  logic [2:0]        elemType,
  input  logic [2:0]        cmpOp,
  input  logic              zeroMode,
  output logic              outValid,
  output logic [DATA_W-1:0] outMask,
  output logic              outErr
);

  localparam int HALF = DATA_W / 2;
  localparam int NB   = DATA_W / 8;

  cmpStrobes_t       st;
  logic [DATA_W-1:0] nextMask;

  simd_cmp_ctrl u_ctrl (
    .elemType  (elemType),
    .cmpOp     (cmpOp),
    .zeroMode  (zeroMode),
    .fullWidth (fullWidth),
    .st        (st)
  );

  simd_cmp_datapath #(.DATA_W(DATA_W)) u_dp (
    .a    (opA),
    .b    (opB),
    .st   (st),
    .mask (nextMask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outErr   <= 1'b0;
      outMask  <= '0;
    end else begin
      outValid <= inValid;
      outErr   <= inValid & st.err;
      outMask  <= inValid ? nextMask : '0;
    end
  end

  // R12: result strobe one clock after the request
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r12_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R11: error forces an empty mask
  a_r11_err_zero: assert property (@(posedge clk) disable iff (rst)
    outErr |-> (outMask == '0));

  // R10: half-width leaves the upper half clear
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (inValid && !fullWidth) |=> (outMask[DATA_W-1:HALF] == '0));

  // R7: unsigned ordered compare against zero is rejected
  a_r7_zero_unsigned: assert property (@(posedge clk) disable iff (rst)
    (inValid && zeroMode && (elemType inside {3'd3, 3'd4, 3'd5}) && cmpOp != 3'd0)
      |=> outErr);

  // R6: less-or-equal / less-than need zero mode
  a_r6_le_needs_zero: assert property (@(posedge clk) disable iff (rst)
    (inValid && !zeroMode && (cmpOp == 3'd3 || cmpOp == 3'd4)) |=> outErr);

  // R1: every byte of the mask is uniformly filled
  for (genvar g = 0; g < NB; g++) begin : g_fill
    a_r1_byte_fill: assert property (@(posedge clk) disable iff (rst)
      outValid |-> (outMask[8*g +: 8] == 8'h00 || outMask[8*g +: 8] == 8'hFF));
  end

endmodule

// File: tb/sim_simd_cmp_unit.sv
`timescale 1ns/1ps
module sim_simd_cmp_unit;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic         fullWidth = 1'b1;
  logic [2:0]   elemType = 3'd0;
  logic [2:0]   cmpOp = 3'd0;
  logic         zeroMode = 1'b0;
  logic         outValid;
  logic [127:0] outMask;
  logic         outErr;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  simd_cmp_unit u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .fullWidth(fullWidth), .elemType(elemType), .cmpOp(cmpOp),
    .zeroMode(zeroMode), .outValid(outValid), .outMask(outMask), .outErr(outErr)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- reference model from the requirements ----------------
  function automatic bit modelErr(bit [2:0] ty, bit [2:0] op, bit zero);
    return (ty == 3'd7) || (op > 3'd4) || (!zero && op >= 3'd3) ||
           (zero && op != 3'd0 && ty >= 3'd3 && ty <= 3'd5);
  endfunction

  function automatic bit isNan(longint unsigned v);
    return (((v >> 23) & 64'hFF) == 64'hFF) && ((v & 64'h7FFFFF) != 0);
  endfunction

  function automatic longint unsigned fkey(longint unsigned v);
    if ((v & 64'h7FFF_FFFF) == 0) return 64'h8000_0000;
    if (v[31])                    return (~v) & 64'hFFFF_FFFF;
    return v | 64'h8000_0000;
  endfunction

  function automatic bit [127:0] modelMask(bit [127:0] a, bit [127:0] b, bit full,
                                           bit [2:0] ty, bit [2:0] op, bit zero);
    bit [127:0] r = '0;
    int w, n;
    if (modelErr(ty, op, zero)) return '0;
    w = (ty == 0 || ty == 3) ? 8 : (ty == 1 || ty == 4) ? 16 : 32;
    n = (full ? 128 : 64) / w;
    for (int k = 0; k < n; k++) begin
      longint unsigned msk, x, y;
      bit unord, hit;
      int ord;
      unord = 1'b0;
      msk = (64'd1 << w) - 1;
      x = 64'(a >> (k * w)) & msk;
      y = zero ? 64'd0 : (64'(b >> (k * w)) & msk);
      if (ty == 3'd6) begin
        unord = isNan(x) || isNan(y);
        x = fkey(x);
        y = fkey(y);
      end else if (ty <= 3'd2) begin
        x ^= 64'd1 << (w - 1);
        y ^= 64'd1 << (w - 1);
      end
      ord = (x < y) ? -1 : (x > y) ? 1 : 0;
      case (op)
        3'd0: hit = (ord == 0);
        3'd1: hit = (ord >= 0);
        3'd2: hit = (ord > 0);
        3'd3: hit = (ord <= 0);
        default: hit = (ord < 0);
      endcase
      if (hit && !unord) r |= 128'(msk) << (k * w);
    end
    return r;
  endfunction

  // ---------------- drivers ----------------
  task automatic issue(input bit [127:0] a, input bit [127:0] b, input bit full,
                       input bit [2:0] ty, input bit [2:0] op, input bit zero,
                       output bit [127:0] m, output bit e, input string req);
    @(negedge clk);
    opA = a; opB = b; fullWidth = full; elemType = ty; cmpOp = op; zeroMode = zero;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " R12 valid"}, 128'(outValid), 128'd1);
    m = outMask;
    e = outErr;
  endtask

  task automatic run(input string req, input bit [127:0] a, input bit [127:0] b,
                     input bit full, input bit [2:0] ty, input bit [2:0] op, input bit zero);
    bit [127:0] m;
    bit e;
    issue(a, b, full, ty, op, zero, m, e, req);
    check({req, " mask"}, m, modelMask(a, b, full, ty, op, zero));
    check({req, " err"}, 128'(e), 128'(modelErr(ty, op, zero)));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 reset valid", 128'(outValid), 128'd0);
    check("R12 reset err", 128'(outErr), 128'd0);
    check("R12 reset mask", outMask, '0);
    rst = 1'b0;
  endtask

  task automatic t_sign_order();
    bit [127:0] m; bit e;
    issue({16{8'h80}}, {16{8'h01}}, 1'b1, 3'd0, 3'd2, 1'b0, m, e, "R4");
    check("R4 S8 GT 0x80>0x01 false", m, '0);
    issue({16{8'h80}}, {16{8'h01}}, 1'b1, 3'd3, 3'd2, 1'b0, m, e, "R4");
    check("R4 U8 GT 0x80>0x01 true", m, {128{1'b1}});
    run("R4 S32 GE", {32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h8000_0000},
                     {32'h0, 32'h8000_0000, 32'h0, 32'h7FFF_FFFF}, 1'b1, 3'd2, 3'd1, 1'b0);
    run("R4 U16 GT", {8{16'h8001}}, {4{16'h8001, 16'h7FFF}}, 1'b1, 3'd4, 3'd2, 1'b0);
  endtask

  task automatic t_eq_agnostic();
    bit [127:0] ms, mu; bit e;
    bit [127:0] a = 128'h00FF_1234_8080_AA55_0000_FFFF_7F80_0102;
    bit [127:0] b = 128'h00FE_1234_8081_AA55_0001_FFFF_7F80_0103;
    issue(a, b, 1'b1, 3'd0, 3'd0, 1'b0, ms, e, "R5");
    issue(a, b, 1'b1, 3'd3, 3'd0, 1'b0, mu, e, "R5");
    check("R5 EQ signed vs unsigned", ms, mu);
    check("R5 EQ S8 value", ms, 128'hFF00_FFFF_FF00_FFFF_FF00_FFFF_FFFF_FF00);
    run("R5 EQ U32", a, b, 1'b1, 3'd5, 3'd0, 1'b0);
  endtask

  task automatic t_ops_widths();
    bit [127:0] a = 128'h8000_7FFF_0001_FFFF_1234_1234_C000_0040;
    bit [127:0] b = 128'h7FFF_8000_0001_0000_1234_1235_C000_0041;
    for (int ty = 0; ty < 6; ty++)
      for (int op = 0; op < 3; op++)
        run($sformatf("R3 R2 type%0d op%0d", ty, op), a, b, 1'b1, 3'(ty), 3'(op), 1'b0);
  endtask

  task automatic t_zero_mode();
    bit [127:0] m1, m2; bit e;
    bit [127:0] a = 128'h8000_0000_7FFF_0001_FFFF_0000_1234_F000;
    for (int op = 0; op < 5; op++)
      run($sformatf("R6 zero S16 op%0d", op), a, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA,
          1'b1, 3'd1, 3'(op), 1'b1);
    issue(a, 128'h0, 1'b1, 3'd1, 3'd3, 1'b1, m1, e, "R6");
    issue(a, {128{1'b1}}, 1'b1, 3'd1, 3'd3, 1'b1, m2, e, "R6");
    check("R6 opB ignored in zero mode", m2, m1);
    check("R6 LE zero S16 value", m1, 128'hFFFF_FFFF_0000_0000_FFFF_FFFF_0000_FFFF);
    run("R6 LT needs zero mode", a, a, 1'b1, 3'd0, 3'd4, 1'b0);
  endtask

  task automatic t_zero_unsigned();
    run("R7 U8 GE zero illegal", {16{8'h00}}, '0, 1'b1, 3'd3, 3'd1, 1'b1);
    run("R7 U32 LT zero illegal", {4{32'h5}}, '0, 1'b1, 3'd5, 3'd4, 1'b1);
    run("R7 U16 EQ zero legal", 128'h0000_0001_0000_FFFF_0000_0000_8000_0000,
        '0, 1'b1, 3'd4, 3'd0, 1'b1);
  endtask

  task automatic t_float();
    bit [127:0] m; bit e;
    bit [127:0] a = {32'h3FC0_0000, 32'hBF80_0000, 32'h0000_0000, 32'h7FC0_0000};
    bit [127:0] b = {32'h3FC0_0000, 32'h4000_0000, 32'h8000_0000, 32'h7FC0_0000};
    issue(a, b, 1'b1, 3'd6, 3'd0, 1'b0, m, e, "R8");
    check("R8 R9 F32 EQ NaN and signed zero", m, {32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0});
    issue(a, b, 1'b1, 3'd6, 3'd1, 1'b0, m, e, "R9");
    check("R8 R9 F32 GE", m, {32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0});
    issue(a, b, 1'b1, 3'd6, 3'd2, 1'b0, m, e, "R9");
    check("R9 F32 GT signed zero not greater", m, '0);
    issue(a, b, 1'b1, 3'd6, 3'd4, 1'b1, m, e, "R8");
    check("R8 F32 LT zero", m, {32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0});
    issue({32'h8000_0000, 32'hFF80_0000, 32'h7F80_0001, 32'h0},
          '0, 1'b1, 3'd6, 3'd3, 1'b1, m, e, "R9");
    check("R9 F32 LE zero (-0, -inf, NaN, +0)", m, {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF});
    run("R8 F32 GT negatives", {32'hC040_0000, 32'hC000_0000, 32'h4040_0000, 32'hFFC0_0000},
        {32'hC000_0000, 32'hC040_0000, 32'h4000_0000, 32'h3F80_0000}, 1'b1, 3'd6, 3'd2, 1'b0);
  endtask

  task automatic t_half();
    bit [127:0] m; bit e;
    issue({8{16'h1234}}, {8{16'h1234}}, 1'b0, 3'd1, 3'd0, 1'b0, m, e, "R10");
    check("R10 half width EQ", m, {64'h0, {64{1'b1}}});
    run("R10 half width S8 GT", 128'h7F7F_7F7F_7F7F_7F7F_0180_7F00_FF01_0203,
        128'h0000_0000_0000_0000_0081_7E00_0001_0302, 1'b0, 3'd0, 3'd2, 1'b0);
  endtask

  task automatic t_illegal();
    bit [127:0] m; bit e;
    run("R11 reserved type", {8{16'h1}}, {8{16'h1}}, 1'b1, 3'd7, 3'd0, 1'b0);
    run("R11 reserved op", {8{16'h1}}, {8{16'h1}}, 1'b1, 3'd1, 3'd6, 1'b0);
    // error and half-width zeroing together
    issue('0, '0, 1'b0, 3'd5, 3'd1, 1'b1, m, e, "R11");
    check("R11 R10 illegal at half width mask", m, '0);
    check("R11 illegal at half width err", 128'(e), 128'd1);
  endtask

  task automatic t_latency();
    @(negedge clk);
    opA = {16{8'h05}}; opB = {16{8'h05}}; fullWidth = 1'b1;
    elemType = 3'd0; cmpOp = 3'd0; zeroMode = 1'b0; inValid = 1'b1;
    @(negedge clk);
    check("R12 back-to-back first valid", 128'(outValid), 128'd1);
    check("R12 back-to-back first mask", outMask, {128{1'b1}});
    opB = {16{8'h06}};
    @(negedge clk);
    check("R12 back-to-back second mask", outMask, '0);
    inValid = 1'b0;
    @(negedge clk);
    check("R12 idle valid", 128'(outValid), 128'd0);
    check("R12 idle mask", outMask, '0);
    // reset while a request is presented
    opB = opA; inValid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R12 reset wins valid", 128'(outValid), 128'd0);
    check("R12 reset wins mask", outMask, '0);
    inValid = 1'b0; rst = 1'b0;
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 300; i++) begin
      bit [127:0] a, b, flip;
      bit [2:0] ty, op;
      a    = {$urandom, $urandom, $urandom, $urandom};
      flip = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
      b    = (i % 3 == 0) ? a : (a ^ flip);
      ty   = 3'($urandom_range(0, 6));
      op   = 3'($urandom_range(0, 4));
      run($sformatf("R1 R2 R3 sweep %0d", i), a, b, 1'($urandom), ty, op, 1'($urandom));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sign_order();
    t_eq_agnostic();
    t_ops_widths();
    t_zero_mode();
    t_zero_unsigned();
    t_float();
    t_half();
    t_illegal();
    t_latency();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule